// File: doc/BRIEF.md
# BCD Time-of-Day Counter with Day Count and Field Alarm

This block keeps wall-clock time for a chip that receives a one-pulse-per-second tick. Seconds, minutes and hours are held as packed BCD bytes. Above them sits a plain 16-bit binary day count, exposed as two byte registers. Software reads and writes all state through a byte-wide register port. Writes take effect at the next clock edge. Reads are combinational on the address.

An alarm compares the minute, hour and day counts against stored values. Each of the three compares has its own enable. A match sets a sticky flag, and that flag drives an interrupt when the interrupt enable is set. A busy bit marks the single clock cycle in which a tick ripples through the counters. A register write that lands in that cycle is held and applied one cycle later, so a tick never collides with a software update.

Top module: `rtc_cal_core`

## Requirements
- R1: When the run bit is set, each tick advances seconds in BCD from 00 to 59. Going from 59 to 00 advances minutes, which also run from 00 to 59 in BCD.
- R2: Minutes going from 59 to 00 advance hours, which run from 00 to 23 in BCD. Hours going from 23 to 00 advance the day count.
- R3: The day count is 16-bit binary. Its low byte is at address 0x18 and its high byte at 0x19. It wraps from 0xFFFF to 0x0000.
- R4: Ticks have no effect while the run bit (control bit 0) is clear.
- R5: The control register is at 0x14. Seconds, minutes and hours are at 0x15, 0x16 and 0x17. Alarm minutes and alarm hours are at 0x1A and 0x1B. The alarm day low and high bytes are at 0x1C and 0x1D. Every other address reads 0x00 and ignores writes. All registers reset to 0x00.
- R6: The control register has the following bits. Bit 5 enables the day compare, bit 4 the hour compare and bit 3 the minute compare. Bit 2 is the alarm flag, bit 1 the interrupt enable and bit 0 the run bit. Bit 7 reads the busy state and ignores writes. Bit 6 reads 0.
- R7: Busy (control bit 7) is high in the cycle where tick_i is high and the run bit is set. A write issued in that cycle is applied at the following clock edge instead.
- R8: The alarm flag sets on a tick that rolls the seconds to 00 while every enabled field equals its new count. If no compare is enabled, the flag never sets.
- R9: The flag is sticky. Writing the control register with bit 2 at 1 clears it. Writing with bit 2 at 0 leaves it unchanged.
- R10: irq_o is high exactly when the alarm flag and the interrupt enable are both set.
- R11: A write to a time or alarm register stores the byte unchanged, including values that are not valid BCD.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse per second |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| irq_o | output | 1 | Alarm interrupt |

## Verification
The bench loads times just below each boundary: seconds to minutes, minutes to hours, hours to days, the day low byte into the high byte, and 0xFFFF back to zero. A broken carry chain would show up as a field stuck at 59 or 23, or as a day count that skips or fails to wrap. It also issues a write in the same cycle as a tick. A design without the hold would either lose the write or let the tick overwrite it.

The alarm is driven through several cases: a single field that matches, a day mismatch that blocks an hour match, and all compares disabled. A design that fired with no compares enabled, or that ignored a disabled or mismatched field, would set the flag when it should not. The flag is also written with bit 2 at 0 and then at 1, to show that it clears only on a one. Finally, the interrupt enable is set after the flag, so that an irq_o gated on the wrong terms would not match.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DAY_W  = 2 * BYTE_W;
  localparam int unsigned N_TOD  = 3;

  localparam logic [ADDR_W-1:0] A_CTRL   = 8'h14;
  localparam logic [ADDR_W-1:0] A_SEC    = 8'h15;
  localparam logic [ADDR_W-1:0] A_MIN    = 8'h16;
  localparam logic [ADDR_W-1:0] A_HR     = 8'h17;
  localparam logic [ADDR_W-1:0] A_DAY_LO = 8'h18;
  localparam logic [ADDR_W-1:0] A_DAY_HI = 8'h19;
  localparam logic [ADDR_W-1:0] A_AMIN   = 8'h1A;
  localparam logic [ADDR_W-1:0] A_AHR    = 8'h1B;
  localparam logic [ADDR_W-1:0] A_ADAY_LO = 8'h1C;
  localparam logic [ADDR_W-1:0] A_ADAY_HI = 8'h1D;

  localparam int unsigned B_BUSY   = 7;
  localparam int unsigned B_DAY_EN = 5;
  localparam int unsigned B_HR_EN  = 4;
  localparam int unsigned B_MIN_EN = 3;
  localparam int unsigned B_FLAG   = 2;
  localparam int unsigned B_IRQ_EN = 1;
  localparam int unsigned B_RUN    = 0;

  typedef struct packed {
    logic [BYTE_W-1:0] sec;
    logic [BYTE_W-1:0] min;
    logic [BYTE_W-1:0] hr;
    logic [DAY_W-1:0]  day;
    logic [BYTE_W-1:0] a_min;
    logic [BYTE_W-1:0] a_hr;
    logic [DAY_W-1:0]  a_day;
    logic              en_day;
    logic              en_hr;
    logic              en_min;
    logic              flag;
    logic              irq_en;
    logic              run;
  } cal_regs_t;

  function automatic cal_regs_t apply_wr(cal_regs_t r, logic [ADDR_W-1:0] a,
                                         logic [BYTE_W-1:0] d);
    cal_regs_t o;
    o = r;
    case (a)
      A_CTRL: begin
        o.en_day = d[B_DAY_EN];
        o.en_hr  = d[B_HR_EN];
        o.en_min = d[B_MIN_EN];
        o.irq_en = d[B_IRQ_EN];
        o.run    = d[B_RUN];
        if (d[B_FLAG]) o.flag = 1'b0;  // write-one-to-clear
      end
      A_SEC:     o.sec = d;
      A_MIN:     o.min = d;
      A_HR:      o.hr  = d;
      A_DAY_LO:  o.day[BYTE_W-1:0] = d;
      A_DAY_HI:  o.day[DAY_W-1:BYTE_W] = d;
      A_AMIN:    o.a_min = d;
      A_AHR:     o.a_hr  = d;
      A_ADAY_LO: o.a_day[BYTE_W-1:0] = d;
      A_ADAY_HI: o.a_day[DAY_W-1:BYTE_W] = d;
      default: ;
    endcase
    return o;
  endfunction
endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] LIMIT = 8'h59
) (
  input  logic [W-1:0] val_i,
  input  logic         inc_i,
  output logic [W-1:0] nxt_o,
  output logic         wrap_o
);
  localparam int unsigned DW = W / 2;

  logic at_lim;
  assign at_lim = (val_i == LIMIT);
  assign wrap_o = inc_i & at_lim;

  always_comb begin
    nxt_o = val_i;
    if (inc_i) begin
      if (at_lim)
        nxt_o = '0;
      else if (val_i[DW-1:0] >= DW'(9))
        nxt_o = {val_i[W-1:DW] + 1'b1, {DW{1'b0}}};
      else
        nxt_o = val_i + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int unsigned BW = 8,
  parameter int unsigned DW = 16
) (
  input  logic          roll_i,
  input  logic [BW-1:0] min_i,
  input  logic [BW-1:0] hr_i,
  input  logic [DW-1:0] day_i,
  input  logic [BW-1:0] a_min_i,
  input  logic [BW-1:0] a_hr_i,
  input  logic [DW-1:0] a_day_i,
  input  logic          en_min_i,
  input  logic          en_hr_i,
  input  logic          en_day_i,
  output logic          hit_o
);
  logic ok_min, ok_hr, ok_day, any_en;

  assign ok_min = ~en_min_i | (min_i == a_min_i);
  assign ok_hr  = ~en_hr_i  | (hr_i  == a_hr_i);
  assign ok_day = ~en_day_i | (day_i == a_day_i);
  assign any_en = en_min_i | en_hr_i | en_day_i;
  assign hit_o  = roll_i & any_en & ok_min & ok_hr & ok_day;
endmodule

// File: rtl/rtc_wr_hold.sv
module rtc_wr_hold #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          busy_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          vld_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else if (busy_i) begin
      if (wr_en_i) begin
        vld_o  <= 1'b1;
        addr_o <= addr_i;
        data_o <= data_i;
      end
    end else begin
      vld_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_cal_core.sv
module rtc_cal_core
  import rtc_cal_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              irq_o
);
  cal_regs_t cur_q, nxt;
  logic busy;
  logic hold_vld;
  logic [ADDR_W-1:0] hold_addr;
  logic [BYTE_W-1:0] hold_data;
  logic [BYTE_W-1:0] tod_cur [N_TOD];
  logic [BYTE_W-1:0] tod_nxt [N_TOD];
  logic              inc    [N_TOD+1];
  logic [DAY_W-1:0]  day_nxt;
  logic              alarm_hit;

  assign busy = tick_i & cur_q.run;

  assign tod_cur[0] = cur_q.sec;
  assign tod_cur[1] = cur_q.min;
  assign tod_cur[2] = cur_q.hr;
  assign inc[0]     = busy;

  for (genvar i = 0; i < N_TOD; i++) begin : g_tod
    rtc_bcd_field #(
      .W    (BYTE_W),
      .LIMIT((i == N_TOD - 1) ? BYTE_W'(8'h23) : BYTE_W'(8'h59))
    ) u_field (
      .val_i (tod_cur[i]),
      .inc_i (inc[i]),
      .nxt_o (tod_nxt[i]),
      .wrap_o(inc[i+1])
    );
  end

  assign day_nxt = inc[N_TOD] ? DAY_W'(cur_q.day + 1'b1) : cur_q.day;

  rtc_alarm_cmp #(.BW(BYTE_W), .DW(DAY_W)) u_alarm (
    .roll_i  (inc[1]),
    .min_i   (tod_nxt[1]),
    .hr_i    (tod_nxt[2]),
    .day_i   (day_nxt),
    .a_min_i (cur_q.a_min),
    .a_hr_i  (cur_q.a_hr),
    .a_day_i (cur_q.a_day),
    .en_min_i(cur_q.en_min),
    .en_hr_i (cur_q.en_hr),
    .en_day_i(cur_q.en_day),
    .hit_o   (alarm_hit)
  );

  rtc_wr_hold #(.AW(ADDR_W), .DW(BYTE_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .busy_i (busy),
    .wr_en_i(wr_en_i),
    .addr_i (addr_i),
    .data_i (wdata_i),
    .vld_o  (hold_vld),
    .addr_o (hold_addr),
    .data_o (hold_data)
  );

  // Tick cycle owns the registers; writes wait one cycle (held, then fresh).
  always_comb begin
    nxt = cur_q;
    if (busy) begin
      nxt.sec = tod_nxt[0];
      nxt.min = tod_nxt[1];
      nxt.hr  = tod_nxt[2];
      nxt.day = day_nxt;
      if (alarm_hit) nxt.flag = 1'b1;
    end else begin
      if (hold_vld) nxt = apply_wr(nxt, hold_addr, hold_data);
      if (wr_en_i)  nxt = apply_wr(nxt, addr_i, wdata_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cur_q <= '0;
    else         cur_q <= nxt;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: begin
        rdata_o[B_BUSY]   = busy;
        rdata_o[B_DAY_EN] = cur_q.en_day;
        rdata_o[B_HR_EN]  = cur_q.en_hr;
        rdata_o[B_MIN_EN] = cur_q.en_min;
        rdata_o[B_FLAG]   = cur_q.flag;
        rdata_o[B_IRQ_EN] = cur_q.irq_en;
        rdata_o[B_RUN]    = cur_q.run;
      end
      A_SEC:     rdata_o = cur_q.sec;
      A_MIN:     rdata_o = cur_q.min;
      A_HR:      rdata_o = cur_q.hr;
      A_DAY_LO:  rdata_o = cur_q.day[BYTE_W-1:0];
      A_DAY_HI:  rdata_o = cur_q.day[DAY_W-1:BYTE_W];
      A_AMIN:    rdata_o = cur_q.a_min;
      A_AHR:     rdata_o = cur_q.a_hr;
      A_ADAY_LO: rdata_o = cur_q.a_day[BYTE_W-1:0];
      A_ADAY_HI: rdata_o = cur_q.a_day[DAY_W-1:BYTE_W];
      default:   rdata_o = '0;
    endcase
  end

  assign irq_o = cur_q.flag & cur_q.irq_en;
endmodule

// File: rtl/rtc_cal_core_chk.sv
module rtc_cal_core_chk
  import rtc_cal_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic              wr_en_i,
  input logic              hold_vld_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [BYTE_W-1:0] rdata_i,
  input logic              irq_i,
  input cal_regs_t         regs_i
);
  AST_SEC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && regs_i.sec == 8'h59 |=> regs_i.sec == 8'h00);  // R1

  AST_HOUR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && regs_i.sec == 8'h59 && regs_i.min == 8'h59 && regs_i.hr == 8'h23
    |=> regs_i.hr == 8'h00);  // R2

  AST_DAY_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && regs_i.sec == 8'h59 && regs_i.min == 8'h59 && regs_i.hr == 8'h23
    && regs_i.day == 16'hFFFF |=> regs_i.day == 16'h0000);  // R3

  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i && !wr_en_i && !hold_vld_i |=> $stable(regs_i));  // R4

  AST_BUSY_WRITE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && wr_en_i |=> hold_vld_i);  // R7

  AST_NO_EN_NO_ALARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !regs_i.en_min && !regs_i.en_hr && !regs_i.en_day && !regs_i.flag && busy_i
    |=> !regs_i.flag);  // R8

  AST_FLAG_CLEARS_BY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(regs_i.flag) |-> $past(wr_en_i || hold_vld_i));  // R9

  AST_IRQ_MATCHES_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == A_CTRL |-> irq_i == (rdata_i[B_FLAG] && rdata_i[B_IRQ_EN]));  // R10
endmodule

bind rtc_cal_core rtc_cal_core_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .busy_i    (busy),
  .wr_en_i   (wr_en_i),
  .hold_vld_i(hold_vld),
  .addr_i    (addr_i),
  .rdata_i   (rdata_o),
  .irq_i     (irq_o),
  .regs_i    (cur_q)
);

// File: tb/tb_rtc_cal_core.sv
module tb_rtc_cal_core;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b0;
  logic wr_en_i = 1'b0;
  logic [7:0] addr_i = 8'h00;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic irq_o;

  int n_total = 0;
  int n_fail = 0;
  string cur_req = "R5";

  // reference model state
  logic [7:0] m_sec = 0, m_min = 0, m_hr = 0, m_amin = 0, m_ahr = 0;
  logic [15:0] m_day = 0, m_aday = 0;
  bit m_run = 0, m_men = 0, m_hen = 0, m_den = 0, m_flag = 0, m_aie = 0;
  bit m_hv = 0;
  logic [7:0] m_ha = 0, m_hd = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rtc_cal_core dut (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic check(input string what, input logic [7:0] act, input logic [7:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] bcd_next(input logic [7:0] v, input int lim, output bit wrapped);
    int n;
    n = int'(v[7:4]) * 10 + int'(v[3:0]);
    wrapped = (n == lim);
    if (wrapped) return 8'h00;
    n = n + 1;
    return 8'((n / 10) * 16 + (n % 10));
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] a, input bit tk);
    case (a)
      8'h14: return {tk && m_run, 1'b0, m_den, m_hen, m_men, m_flag, m_aie, m_run};
      8'h15: return m_sec;
      8'h16: return m_min;
      8'h17: return m_hr;
      8'h18: return m_day[7:0];
      8'h19: return m_day[15:8];
      8'h1A: return m_amin;
      8'h1B: return m_ahr;
      8'h1C: return m_aday[7:0];
      8'h1D: return m_aday[15:8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_wr(input logic [7:0] a, input logic [7:0] d);
    case (a)
      8'h14: begin
        m_den = d[5]; m_hen = d[4]; m_men = d[3]; m_aie = d[1]; m_run = d[0];
        if (d[2]) m_flag = 0;
      end
      8'h15: m_sec = d;
      8'h16: m_min = d;
      8'h17: m_hr = d;
      8'h18: m_day[7:0] = d;
      8'h19: m_day[15:8] = d;
      8'h1A: m_amin = d;
      8'h1B: m_ahr = d;
      8'h1C: m_aday[7:0] = d;
      8'h1D: m_aday[15:8] = d;
      default: ;
    endcase
  endtask

  task automatic model_edge(input bit tk, input bit wr, input logic [7:0] a, input logic [7:0] d);
    bit w0, w1, w2;
    if (tk && m_run) begin
      w1 = 0; w2 = 0;
      m_sec = bcd_next(m_sec, 59, w0);
      if (w0) m_min = bcd_next(m_min, 59, w1);
      if (w0 && w1) m_hr = bcd_next(m_hr, 23, w2);
      if (w0 && w1 && w2) m_day = m_day + 16'd1;
      if (w0 && (m_men || m_hen || m_den) && (!m_men || m_amin == m_min)
          && (!m_hen || m_ahr == m_hr) && (!m_den || m_aday == m_day))
        m_flag = 1;
      if (wr) begin m_hv = 1; m_ha = a; m_hd = d; end
    end else begin
      if (m_hv) model_wr(m_ha, m_hd);
      if (wr) model_wr(a, d);
      m_hv = 0;
    end
  endtask

  // one clock: drive, compare against model, then advance model on the edge
  task automatic step(input bit tk, input bit wr, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    tick_i = tk; wr_en_i = wr; addr_i = a; wdata_i = d;
    #1;
    check($sformatf("rdata@%h", a), rdata_o, exp_read(a, tk));
    check("irq", {7'd0, irq_o}, {7'd0, m_flag && m_aie});
    @(posedge clk);
    model_edge(tk, wr, a, d);
  endtask

  task automatic rd(input logic [7:0] a); step(0, 0, a, 8'h00); endtask
  task automatic wrr(input logic [7:0] a, input logic [7:0] d); step(0, 1, a, d); endtask
  task automatic tk(); step(1, 0, 8'h14, 8'h00); endtask

  task automatic expect_rd(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk);
    tick_i = 0; wr_en_i = 0; addr_i = a;
    #1;
    check($sformatf("direct@%h", a), rdata_o, v);
    @(posedge clk);
    model_edge(0, 0, a, 8'h00);
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                          input logic [15:0] day);
    wrr(8'h17, h); wrr(8'h16, m); wrr(8'h15, s);
    wrr(8'h18, day[7:0]); wrr(8'h19, day[15:8]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_total++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R5: reset values and unmapped addresses
    cur_req = "R5";
    for (int a = 8'h14; a <= 8'h1D; a++) expect_rd(8'(a), 8'h00);
    wrr(8'h00, 8'h55); wrr(8'h1E, 8'hAA);
    expect_rd(8'h00, 8'h00);
    expect_rd(8'h1E, 8'h00);

    // R11: raw stores, including non-BCD
    cur_req = "R11";
    wrr(8'h17, 8'h3F); expect_rd(8'h17, 8'h3F);
    wrr(8'h15, 8'hAB); expect_rd(8'h15, 8'hAB);
    wrr(8'h1B, 8'hC7); expect_rd(8'h1B, 8'hC7);
    wrr(8'h1B, 8'h00);

    // R4: no counting with run clear
    cur_req = "R4";
    set_time(8'h01, 8'h02, 8'h10, 16'h0003);
    tk(); tk(); tk();
    expect_rd(8'h15, 8'h10);

    // R6: control bit layout
    cur_req = "R6";
    wrr(8'h14, 8'hFF); expect_rd(8'h14, 8'h3B);
    wrr(8'h14, 8'h01); expect_rd(8'h14, 8'h01);

    // R1: seconds and minute carry
    cur_req = "R1";
    set_time(8'h12, 8'h34, 8'h58, 16'h0000);
    tk(); expect_rd(8'h15, 8'h59);
    tk(); expect_rd(8'h15, 8'h00); expect_rd(8'h16, 8'h35); expect_rd(8'h17, 8'h12);
    set_time(8'h00, 8'h09, 8'h09, 16'h0000);
    tk(); expect_rd(8'h15, 8'h10);

    // R2: hour carry into day, day low into high
    cur_req = "R2";
    set_time(8'h23, 8'h59, 8'h59, 16'h00FF);
    tk();
    expect_rd(8'h17, 8'h00); expect_rd(8'h16, 8'h00);
    cur_req = "R3";
    expect_rd(8'h18, 8'h00); expect_rd(8'h19, 8'h01);

    // R3: day wrap
    set_time(8'h23, 8'h59, 8'h59, 16'hFFFF);
    tk();
    expect_rd(8'h18, 8'h00); expect_rd(8'h19, 8'h00);

    // R7: busy flag and a write held across the tick
    cur_req = "R7";
    set_time(8'h05, 8'h06, 8'h07, 16'h0001);
    step(1, 1, 8'h15, 8'h42);
    expect_rd(8'h15, 8'h08);
    expect_rd(8'h15, 8'h42);
    @(negedge clk); tick_i = 1; wr_en_i = 0; addr_i = 8'h14; #1;
    check("busy bit", rdata_o, 8'h81);
    @(posedge clk); model_edge(1, 0, 8'h14, 8'h00);

    // R8: minute-only alarm
    cur_req = "R8";
    wrr(8'h1A, 8'h01); wrr(8'h1B, 8'h00);
    set_time(8'h00, 8'h00, 8'h58, 16'h0005);
    wrr(8'h14, 8'h0B);
    tk(); expect_rd(8'h14, 8'h0B);
    tk(); expect_rd(8'h14, 8'h0F);
    cur_req = "R10";
    check("irq after hit", {7'd0, irq_o}, 8'h01);

    // R9: sticky flag, write-one-to-clear
    cur_req = "R9";
    wrr(8'h14, 8'h0B); expect_rd(8'h14, 8'h0F);
    wrr(8'h14, 8'h0F); expect_rd(8'h14, 8'h0B);

    // R10: flag without enable, then enable
    cur_req = "R10";
    wrr(8'h14, 8'h09);
    set_time(8'h00, 8'h00, 8'h59, 16'h0005);
    tk(); expect_rd(8'h14, 8'h0D);
    check("irq masked", {7'd0, irq_o}, 8'h00);
    wrr(8'h14, 8'h0B); expect_rd(8'h14, 8'h0F);
    check("irq unmasked", {7'd0, irq_o}, 8'h01);

    // R8: no compares enabled
    cur_req = "R8";
    wrr(8'h14, 8'h07);
    set_time(8'h00, 8'h00, 8'h59, 16'h0005);
    tk(); expect_rd(8'h14, 8'h03);

    // R8: hour+day compare, day mismatch then match
    wrr(8'h1C, 8'h07); wrr(8'h1D, 8'h00);
    wrr(8'h14, 8'h33);
    set_time(8'h00, 8'h00, 8'h59, 16'h0005);
    tk(); expect_rd(8'h14, 8'h33);
    set_time(8'h23, 8'h59, 8'h59, 16'h0006);
    tk(); expect_rd(8'h14, 8'h37);

    // R1: long run against the model, reading every address in turn
    cur_req = "R1";
    wrr(8'h14, 8'h3F);
    set_time(8'h23, 8'h58, 8'h30, 16'h0006);
    for (int i = 0; i < 600; i++) begin
      step((i % 3) == 0, 0, 8'(8'h14 + (i % 10)), 8'h00);
    end

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule